// File: doc/BRIEF.md
# Vectored Two-Bank Interrupt Controller

This block gathers sixteen interrupt sources into a single request line for a processor. The sources are split into an upper bank (A, sources 15..8) and a lower bank (B, sources 7..0). Each bank keeps four byte-wide registers that software can read and write: enable, pending, in-service and mask. A shared vector byte supplies the upper half of every vector the block returns. Each source arrives as a one-cycle strobe. Edge detection happens before this block.

When the processor acknowledges the request, the block returns the vector of the highest-priority request that is eligible. It then retires that request. In software end-of-interrupt mode the block also marks the source as in service. That mark holds off requests of equal and lower priority until software clears it.

The acknowledge path is a valid/ready handshake. The processor raises `ack_valid` and holds it until `ack_ready` is high. The block raises `ack_ready` only while it has a request to serve. While `ack_ready` is high, `ack_vector` is valid in that same cycle. A transfer takes place on any rising edge where both signals are high. The register bus and the strobes have no back-pressure.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset every register (enable, pending, in-service and mask of both banks, and the vector byte) reads 0, and `irq` and `ack_ready` are low.
- R2: A strobe on source n sets its pending bit at the next edge only if its enable bit was already 1 before that edge. A strobe on a disabled source leaves its pending bit at 0.
- R3: Writing 0 to an enable bit clears the matching pending bit at the same edge. A pending bit is never 1 while its enable bit is 0.
- R4: A register-bus write to a pending or in-service register clears each bit written as 0 and leaves each bit written as 1 unchanged.
- R5: A mask bit of 1 lets its pending source request, and a mask bit of 0 holds that source off. The pending bit of a held-off source is still recorded. `irq` is low when no pending bit has its mask bit set.
- R6: Priority runs from source 15, the highest, down to source 0. Source n is bank A bit n-8 for n >= 8 and bank B bit n otherwise. The low nibble of `ack_vector` is the number of the winning source.
- R7: The high nibble of `ack_vector` equals bits 7:4 of the vector byte.
- R8: `ack_ready` equals `irq`. A transfer clears the winning source's pending bit at that edge.
- R9: When bit 3 of the vector byte is 1 (software end-of-interrupt), a transfer sets the winner's in-service bit. When bit 3 is 0, in-service bits are never set.
- R10: If in-service bit k is set, no source numbered k or lower can raise `irq` or win. Only pending, unmasked sources above the highest set in-service bit are eligible.
- R11: The register map for `reg_sel` is as follows. 0 and 1 are enable A and B. 2 and 3 are pending A and B. 4 and 5 are in-service A and B. 6 and 7 are mask A and B. 8 is the vector byte. The values 9 to 15 read 0 and writes to them are ignored. `reg_rdata` is combinational on `reg_sel`.
- R12: A strobe on an enabled source overrides a clear of the same pending bit by a transfer or by a software write in the same cycle, so the bit stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 4 | Register select for read and write |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| src_strobe | input | 16 | One-cycle event per source, bit n = source n |
| irq | output | 1 | Interrupt request to the processor |
| ack_valid | input | 1 | Processor acknowledge request |
| ack_ready | output | 1 | Block can answer an acknowledge |
| ack_vector | output | 8 | Vector of the winning source, valid while `ack_ready` is high |

## Verification
Some properties are checked by assertions on every cycle. A pending bit never outlives its enable bit. The chosen winner is always pending, unmasked and above every in-service bit. A transfer always retires its winner unless a strobe arrives in the same cycle. In-service bits rise only through a transfer in software end-of-interrupt mode. Other behaviour can only be shown by the bench scenarios. These are the exact vector values, the ordering between two competing sources, and the write-one-keeps rule on the register bus. They also include a masked source coming back once it is unmasked, and the release of lower requests after software clears an in-service bit.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int ADDR_W   = 4;
  localparam int SEOI_BIT = 3;

  localparam logic [ADDR_W-1:0] RA_EN_A   = 4'd0;
  localparam logic [ADDR_W-1:0] RA_EN_B   = 4'd1;
  localparam logic [ADDR_W-1:0] RA_PEND_A = 4'd2;
  localparam logic [ADDR_W-1:0] RA_PEND_B = 4'd3;
  localparam logic [ADDR_W-1:0] RA_SVC_A  = 4'd4;
  localparam logic [ADDR_W-1:0] RA_SVC_B  = 4'd5;
  localparam logic [ADDR_W-1:0] RA_MASK_A = 4'd6;
  localparam logic [ADDR_W-1:0] RA_MASK_B = 4'd7;
  localparam logic [ADDR_W-1:0] RA_VEC    = 4'd8;
endpackage

// File: rtl/vic_bank.sv
module vic_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         wr_pend,
  input  logic         wr_svc,
  input  logic         wr_mask,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] strobe,
  input  logic [W-1:0] ack_hit,
  input  logic         svc_set,
  output logic [W-1:0] en_q,
  output logic [W-1:0] pend_q,
  output logic [W-1:0] svc_q,
  output logic [W-1:0] mask_q
);
  logic [W-1:0] en_d, pend_keep, pend_d, svc_keep, svc_d;

  always_comb begin
    en_d      = wr_en ? wdata : en_q;
    pend_keep = pend_q & ~ack_hit;
    if (wr_pend) pend_keep = pend_keep & wdata;
    pend_d    = (pend_keep | (strobe & en_q)) & en_d;
    svc_keep  = wr_svc ? (svc_q & wdata) : svc_q;
    svc_d     = svc_keep | (svc_set ? ack_hit : '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      pend_q <= '0;
      svc_q  <= '0;
      mask_q <= '0;
    end else begin
      en_q   <= en_d;
      pend_q <= pend_d;
      svc_q  <= svc_d;
      if (wr_mask) mask_q <= wdata;
    end
  end

  // R3
  pend_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q & ~en_q) == '0);

  // R9
  svc_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !svc_set |=> (svc_q & ~$past(svc_q)) == '0);
endmodule

// File: rtl/vic_prio.sv
module vic_prio #(
  parameter int N    = 16,
  parameter int ID_W = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    pend,
  input  logic [N-1:0]    mask,
  input  logic [N-1:0]    svc,
  output logic            req,
  output logic [ID_W-1:0] win_id
);
  logic [N-1:0] elig;
  logic         blk;

  always_comb begin
    blk = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (svc[i]) blk = 1'b1;
      elig[i] = pend[i] & mask[i] & ~blk;
    end
    win_id = '0;
    for (int i = 0; i < N; i++) begin
      if (elig[i]) win_id = ID_W'(i);
    end
    req = |elig;
  end

  // R6
  winner_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> (pend[win_id] && mask[win_id]));

  // R10
  winner_above_svc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> ((svc >> win_id) == '0));
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vic_pkg::*;
#(
  parameter int BANK_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   reg_sel,
  input  logic                reg_wr,
  input  logic [BANK_W-1:0]   reg_wdata,
  output logic [BANK_W-1:0]   reg_rdata,
  input  logic [2*BANK_W-1:0] src_strobe,
  output logic                irq,
  input  logic                ack_valid,
  output logic                ack_ready,
  output logic [BANK_W-1:0]   ack_vector
);
  localparam int N    = 2 * BANK_W;
  localparam int ID_W = $clog2(N);

  logic [N-1:0]      en_all, pend_all, svc_all, mask_all, ack_hit_all;
  logic [BANK_W-1:0] vr_q;
  logic              req, ack_fire, seoi;
  logic [ID_W-1:0]   win_id;

  assign seoi        = vr_q[SEOI_BIT];
  assign ack_fire    = ack_valid && req;
  assign ack_hit_all = ack_fire ? (N'(1) << win_id) : '0;

  // bank 1 = A (upper sources), bank 0 = B (lower sources)
  for (genvar b = 0; b < 2; b++) begin : g_bank
    localparam logic [ADDR_W-1:0] A_EN   = (b == 1) ? RA_EN_A   : RA_EN_B;
    localparam logic [ADDR_W-1:0] A_PEND = (b == 1) ? RA_PEND_A : RA_PEND_B;
    localparam logic [ADDR_W-1:0] A_SVC  = (b == 1) ? RA_SVC_A  : RA_SVC_B;
    localparam logic [ADDR_W-1:0] A_MASK = (b == 1) ? RA_MASK_A : RA_MASK_B;
    vic_bank #(.W(BANK_W)) i_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (reg_wr && reg_sel == A_EN),
      .wr_pend (reg_wr && reg_sel == A_PEND),
      .wr_svc  (reg_wr && reg_sel == A_SVC),
      .wr_mask (reg_wr && reg_sel == A_MASK),
      .wdata   (reg_wdata),
      .strobe  (src_strobe[b*BANK_W +: BANK_W]),
      .ack_hit (ack_hit_all[b*BANK_W +: BANK_W]),
      .svc_set (seoi),
      .en_q    (en_all[b*BANK_W +: BANK_W]),
      .pend_q  (pend_all[b*BANK_W +: BANK_W]),
      .svc_q   (svc_all[b*BANK_W +: BANK_W]),
      .mask_q  (mask_all[b*BANK_W +: BANK_W])
    );
  end

  vic_prio #(.N(N), .ID_W(ID_W)) i_prio (
    .clk    (clk),
    .rst_n  (rst_n),
    .pend   (pend_all),
    .mask   (mask_all),
    .svc    (svc_all),
    .req    (req),
    .win_id (win_id)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                        vr_q <= '0;
    else if (reg_wr && reg_sel == RA_VEC) vr_q <= reg_wdata;
  end

  always_comb begin
    case (reg_sel)
      RA_EN_A:   reg_rdata = en_all[N-1:BANK_W];
      RA_EN_B:   reg_rdata = en_all[BANK_W-1:0];
      RA_PEND_A: reg_rdata = pend_all[N-1:BANK_W];
      RA_PEND_B: reg_rdata = pend_all[BANK_W-1:0];
      RA_SVC_A:  reg_rdata = svc_all[N-1:BANK_W];
      RA_SVC_B:  reg_rdata = svc_all[BANK_W-1:0];
      RA_MASK_A: reg_rdata = mask_all[N-1:BANK_W];
      RA_MASK_B: reg_rdata = mask_all[BANK_W-1:0];
      RA_VEC:    reg_rdata = vr_q;
      default:   reg_rdata = '0;
    endcase
  end

  assign irq        = req;
  assign ack_ready  = req;
  assign ack_vector = {vr_q[BANK_W-1:ID_W], win_id};

  // R8
  ack_retires_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> ((pend_all & $past(ack_hit_all) & ~$past(src_strobe)) == '0));

  // R9
  seoi_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire && seoi) |=> ((svc_all & $past(ack_hit_all)) != '0));

  // R9
  aeoi_no_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire && !seoi) |=> ((svc_all & ~$past(svc_all)) == '0));

  // R5
  no_live_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_all & mask_all) == '0) |-> !irq);
endmodule

// File: tb/test_vec_irq_ctrl.sv
module test_vec_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  reg_sel = '0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [15:0] src_strobe = '0;
  logic        irq, ack_ready, ack_valid = 1'b0;
  logic [7:0]  ack_vector;

  int tests = 0, fails = 0;
  bit [15:0] m_en, m_pend, m_svc, m_mask;
  bit [7:0]  m_vr;

  always #5 clk = ~clk;

  vec_irq_ctrl i_vec_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_strobe(src_strobe),
    .irq(irq), .ack_valid(ack_valid), .ack_ready(ack_ready),
    .ack_vector(ack_vector)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // returns {req, id}
  function automatic logic [4:0] m_win();
    bit blk = 0;
    logic [4:0] r = '0;
    for (int i = 15; i >= 0; i--) begin
      if (m_svc[i]) blk = 1;
      if (!blk && m_pend[i] && m_mask[i] && !r[4]) r = {1'b1, 4'(i)};
    end
    return r;
  endfunction

  function automatic logic [7:0] m_read(input logic [3:0] s);
    case (s)
      0: return m_en[15:8];   1: return m_en[7:0];
      2: return m_pend[15:8]; 3: return m_pend[7:0];
      4: return m_svc[15:8];  5: return m_svc[7:0];
      6: return m_mask[15:8]; 7: return m_mask[7:0];
      8: return m_vr;
      default: return 8'h00;
    endcase
  endfunction

  // one clock cycle, started and ended at a falling edge
  task automatic cycle(input logic [3:0] s, input bit wr, input logic [7:0] wd,
                       input logic [15:0] st, input bit av);
    logic [4:0] w;
    bit fire;
    bit [15:0] hit, en_n, pk, sk;
    reg_sel = s; reg_wr = wr; reg_wdata = wd; src_strobe = st; ack_valid = av;
    #1;
    w = m_win();
    check(reg_rdata, m_read(s), "R11 rdata");
    check({7'd0, irq}, {7'd0, w[4]}, "R5/R10 irq");
    check({7'd0, ack_ready}, {7'd0, w[4]}, "R8 ready");
    if (w[4]) begin
      check({4'd0, ack_vector[3:0]}, {4'd0, w[3:0]}, "R6 vector id");
      check({4'd0, ack_vector[7:4]}, {4'd0, m_vr[7:4]}, "R7 vector high");
    end
    fire = av && w[4];
    hit  = fire ? (16'd1 << w[3:0]) : 16'd0;
    en_n = m_en;
    if (wr && s == 0) en_n[15:8] = wd;
    if (wr && s == 1) en_n[7:0]  = wd;
    pk = m_pend & ~hit;
    if (wr && s == 2) pk[15:8] = pk[15:8] & wd;
    if (wr && s == 3) pk[7:0]  = pk[7:0] & wd;
    sk = m_svc;
    if (wr && s == 4) sk[15:8] = sk[15:8] & wd;
    if (wr && s == 5) sk[7:0]  = sk[7:0] & wd;
    @(posedge clk);
    m_pend = (pk | (st & m_en)) & en_n;
    m_svc  = sk | ((fire && m_vr[3]) ? hit : 16'd0);
    m_en   = en_n;
    if (wr && s == 6) m_mask[15:8] = wd;
    if (wr && s == 7) m_mask[7:0]  = wd;
    if (wr && s == 8) m_vr = wd;
    @(negedge clk);
    reg_wr = 0; src_strobe = '0; ack_valid = 0;
  endtask

  task automatic wr_reg(input logic [3:0] s, input logic [7:0] d);
    cycle(s, 1, d, 16'd0, 0);
  endtask

  task automatic peek(input logic [3:0] s, input logic [7:0] exp, input string tag);
    reg_sel = s; reg_wr = 0; #1;
    check(reg_rdata, exp, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int a = 0; a < 9; a++) peek(4'(a), 8'h00, "R1 reg");
    check({7'd0, irq}, 8'h00, "R1 irq");
    check({7'd0, ack_ready}, 8'h00, "R1 ready");
    // R2 enabled vs disabled strobe
    wr_reg(1, 8'h01);
    cycle(0, 0, 0, 16'h0003, 0);
    peek(3, 8'h01, "R2 pend B");
    // R3 enable clear drops pending
    wr_reg(1, 8'h00);
    peek(3, 8'h00, "R3 pend B");
    // R4 write 0 clears, 1 keeps
    wr_reg(1, 8'h03);
    cycle(0, 0, 0, 16'h0003, 0);
    wr_reg(3, 8'hFE);
    peek(3, 8'h02, "R4 clear");
    wr_reg(3, 8'hFF);
    peek(3, 8'h02, "R4 keep");
    // R5 masked source pending but silent
    #1 check({7'd0, irq}, 8'h00, "R5 masked");
    wr_reg(7, 8'h02);
    #1 check({7'd0, irq}, 8'h01, "R5 unmasked");
    // R6/R7 priority and vector
    wr_reg(0, 8'h80); wr_reg(6, 8'h80); wr_reg(8, 8'hA8);
    cycle(0, 0, 0, 16'h8000, 0);
    #1 check(ack_vector, 8'hAF, "R6/R7 vector");
    // R9 seoi: ack marks in-service; R10 holds off lower
    cycle(0, 0, 0, 16'h0000, 1);
    peek(4, 8'h80, "R9 svc A");
    peek(2, 8'h00, "R8 pend A");
    check({7'd0, irq}, 8'h00, "R10 held");
    wr_reg(4, 8'h7F);
    #1 check(ack_vector, 8'hA1, "R10 released");
    // R9 aeoi: no mark; R12 strobe beats ack clear
    wr_reg(8, 8'h50);
    cycle(0, 0, 0, 16'h0002, 1);
    peek(5, 8'h00, "R9 aeoi svc");
    peek(3, 8'h02, "R12 pend kept");
    // random phase
    for (int k = 0; k < 4000; k++) begin
      logic [15:0] st;
      st = 16'($urandom) & 16'($urandom) & 16'($urandom);
      cycle(4'($urandom_range(0, 10)), ($urandom_range(0, 3) == 0),
            8'($urandom), st, $urandom_range(0, 1) == 1);
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule